// File: doc/BRIEF.md
# Two-Symbol Home Device Menu Controller

This block turns a stream of binary class decisions into on/off commands for a small set of home devices, such as a door lock, the lighting and the air conditioning. Each decision comes with a strobe and carries one of two symbols. The step symbol moves the highlight forward. The confirm symbol acts on the highlighted entry.

The menu has two nested levels. At the device level, step moves to the next device and confirm selects the highlighted one. At the action level, step cycles through the switch-on, switch-off and return options, and confirm carries out the highlighted option. Carrying out switch-on or switch-off emits a single-cycle command pulse that holds the device index and the on/off value. The menu then returns to the device level on the same device.

Top module: `home_menu_ctrl`

## Requirements
- R1: After reset, menu_level is 0 (device level), cur_dev is 0, cur_opt is 0 (switch-on) and cmd_valid is low.
- R2: A decision is taken only when dec_valid is high and dec_class is 2'b01 (step) or 2'b10 (confirm). A strobe with dec_class 2'b00 or 2'b11, or any cycle with dec_valid low, leaves menu_level, cur_dev and cur_opt unchanged and produces no command.
- R3: A step at the device level raises cur_dev by one. The new value shows in the cycle after the strobe.
- R4: A step at the device level when cur_dev is NUM_DEV-1 sets cur_dev to 0.
- R5: A confirm at the device level sets menu_level to 1 (action level) with cur_opt 0 (switch-on) and leaves cur_dev unchanged.
- R6: A step at the action level moves cur_opt through the encoding switch-on=0, switch-off=1, return=2, and from 2 back to 0.
- R7: A confirm at the action level with cur_opt 0 or 1 raises cmd_valid for exactly the next cycle. In that cycle cmd_dev equals cur_dev, and cmd_on is 1 for switch-on and 0 for switch-off. In the same cycle menu_level is 0, cur_dev is unchanged and cur_opt is 0.
- R8: A confirm at the action level with cur_opt 2 returns to the device level with cur_dev unchanged and cur_opt 0, and produces no command.
- R9: cmd_valid is never high in two consecutive cycles, and at the device level cur_opt is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Decision strobe |
| dec_class | input | 2 | Decision symbol: 01 step, 10 confirm |
| menu_level | output | 1 | 0 device level, 1 action level |
| cur_dev | output | DEV_W | Highlighted or selected device index |
| cur_opt | output | 2 | Highlighted action option |
| cmd_valid | output | 1 | Single-cycle command pulse |
| cmd_dev | output | DEV_W | Device index of the last command |
| cmd_on | output | 1 | On/off value of the last command |

## Verification
A corrupted level flag or option register appears at the ports in the very next cycle, because menu_level and cur_opt are registered outputs. A confirm taken on the wrong level also shows at once, either as a spurious or missing cmd_valid or as a wrong cmd_on. A device counter that drifts or fails to wrap shows in cur_dev one cycle after the step. The same fault then reappears in cmd_dev on the next command. Long random decision streams, including malformed strobes, mixed with directed wrap and return sequences, compare every output against an independent menu model after every cycle.

// File: rtl/hsel_pkg.sv
package hsel_pkg;

  typedef enum logic {
    LVL_DEV = 1'b0,
    LVL_ACT = 1'b1
  } level_e;

  typedef enum logic [1:0] {
    OPT_ON   = 2'd0,
    OPT_OFF  = 2'd1,
    OPT_BACK = 2'd2
  } opt_e;

  // next highlighted action option, cycling on -> off -> back -> on
  function automatic opt_e opt_after(opt_e cur);
    case (cur)
      OPT_ON:  return OPT_OFF;
      OPT_OFF: return OPT_BACK;
      default: return OPT_ON;
    endcase
  endfunction

  // an option that issues a command when confirmed
  function automatic logic opt_is_cmd(opt_e cur);
    return (cur == OPT_ON) || (cur == OPT_OFF);
  endfunction

endpackage

// File: rtl/hsel_decode.sv
module hsel_decode (
  input  logic       dec_valid,
  input  logic [1:0] dec_class,
  output logic       step_evt,
  output logic       conf_evt
);
  // exactly one class bit must be set for the strobe to count
  always_comb begin
    step_evt = dec_valid && (dec_class == 2'b01);
    conf_evt = dec_valid && (dec_class == 2'b10);
  end
endmodule

// File: rtl/hsel_dev_ptr.sv
module hsel_dev_ptr #(
  parameter int NUM_DEV = 4,
  parameter int DEV_W   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [DEV_W-1:0] dev_q
);
  localparam logic [DEV_W-1:0] LAST_IDX = DEV_W'(NUM_DEV - 1);

  function automatic logic [DEV_W-1:0] dev_after(logic [DEV_W-1:0] cur);
    if (cur == LAST_IDX) return '0;
    return cur + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)   dev_q <= '0;
    else if (adv) dev_q <= dev_after(dev_q);
  end
endmodule

// File: rtl/hsel_act_ptr.sv
module hsel_act_ptr
  import hsel_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic clear,
  output opt_e opt_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)     opt_q <= OPT_ON;
    else if (clear) opt_q <= OPT_ON;
    else if (adv)   opt_q <= opt_after(opt_q);
  end
endmodule

// File: rtl/home_menu_ctrl.sv
module home_menu_ctrl
  import hsel_pkg::*;
#(
  parameter int NUM_DEV = 4,
  parameter int DEV_W   = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dec_valid,
  input  logic [1:0]       dec_class,
  output logic             menu_level,
  output logic [DEV_W-1:0] cur_dev,
  output logic [1:0]       cur_opt,
  output logic             cmd_valid,
  output logic [DEV_W-1:0] cmd_dev,
  output logic             cmd_on
);
  // named internal events, visible to the bound checker
  logic step_evt, conf_evt;
  logic dev_adv, dev_sel, opt_adv, act_exec, cmd_fire;

  level_e           level_q;
  opt_e             opt_q;
  logic [DEV_W-1:0] dev_q;
  logic             cmd_valid_q, cmd_on_q;
  logic [DEV_W-1:0] cmd_dev_q;

  hsel_decode u_dec (
    .dec_valid (dec_valid),
    .dec_class (dec_class),
    .step_evt  (step_evt),
    .conf_evt  (conf_evt)
  );

  always_comb begin
    dev_adv  = step_evt && (level_q == LVL_DEV);
    dev_sel  = conf_evt && (level_q == LVL_DEV);
    opt_adv  = step_evt && (level_q == LVL_ACT);
    act_exec = conf_evt && (level_q == LVL_ACT);
    cmd_fire = act_exec && opt_is_cmd(opt_q);
  end

  hsel_dev_ptr #(.NUM_DEV(NUM_DEV), .DEV_W(DEV_W)) u_dev (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (dev_adv),
    .dev_q (dev_q)
  );

  hsel_act_ptr u_act (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (opt_adv),
    .clear (act_exec),
    .opt_q (opt_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)        level_q <= LVL_DEV;
    else if (dev_sel)  level_q <= LVL_ACT;
    else if (act_exec) level_q <= LVL_DEV;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_valid_q <= 1'b0;
      cmd_dev_q   <= '0;
      cmd_on_q    <= 1'b0;
    end else begin
      cmd_valid_q <= cmd_fire;
      if (cmd_fire) begin
        cmd_dev_q <= dev_q;
        cmd_on_q  <= (opt_q == OPT_ON);
      end
    end
  end

  assign menu_level = level_q;
  assign cur_dev    = dev_q;
  assign cur_opt    = opt_q;
  assign cmd_valid  = cmd_valid_q;
  assign cmd_dev    = cmd_dev_q;
  assign cmd_on     = cmd_on_q;
endmodule

// File: rtl/home_menu_ctrl_chk.sv
module home_menu_ctrl_chk #(
  parameter int NUM_DEV = 4,
  parameter int DEV_W   = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dec_valid,
  input logic [1:0]       dec_class,
  input logic             menu_level,
  input logic [DEV_W-1:0] cur_dev,
  input logic [1:0]       cur_opt,
  input logic             cmd_valid,
  input logic [DEV_W-1:0] cmd_dev,
  input logic             cmd_on,
  input logic             step_evt,
  input logic             conf_evt
);
  logic bad_strobe;
  assign bad_strobe = !dec_valid || (dec_class == 2'b00) || (dec_class == 2'b11);

  // R2
  ignored_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_strobe |=> ($stable(menu_level) && $stable(cur_dev) && $stable(cur_opt) && !cmd_valid));

  // R3
  dev_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && !menu_level && cur_dev != DEV_W'(NUM_DEV-1)) |=> (cur_dev == $past(cur_dev) + 1'b1));

  // R4
  dev_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && !menu_level && cur_dev == DEV_W'(NUM_DEV-1)) |=> (cur_dev == '0));

  // R5
  dev_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conf_evt && !menu_level) |=> (menu_level && cur_opt == 2'd0 && $stable(cur_dev)));

  // R6
  opt_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && menu_level) |=> (menu_level && cur_opt == (($past(cur_opt) == 2'd2) ? 2'd0 : $past(cur_opt) + 2'd1)));

  // R7
  cmd_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conf_evt && menu_level && cur_opt != 2'd2) |=>
      (cmd_valid && cmd_dev == $past(cur_dev) && cmd_on == ($past(cur_opt) == 2'd0) && !menu_level));

  // R8
  back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conf_evt && menu_level && cur_opt == 2'd2) |=> (!menu_level && !cmd_valid && $stable(cur_dev)));

  // R9
  one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  // R9
  dev_level_opt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !menu_level |-> (cur_opt == 2'd0));
endmodule

bind home_menu_ctrl home_menu_ctrl_chk #(.NUM_DEV(NUM_DEV), .DEV_W(DEV_W)) chk_i (.*);

// File: tb/home_menu_ctrl_tb_top.sv
module home_menu_ctrl_tb_top;
  localparam int NUM_DEV = 4;
  localparam int DEV_W   = 2;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             dec_valid = 1'b0;
  logic [1:0]       dec_class = 2'b00;
  logic             menu_level;
  logic [DEV_W-1:0] cur_dev;
  logic [1:0]       cur_opt;
  logic             cmd_valid;
  logic [DEV_W-1:0] cmd_dev;
  logic             cmd_on;

  int tests = 0;
  int fails = 0;

  // bench model of the menu
  int m_lvl, m_dev, m_opt, m_cmd_dev, m_cmd_on;
  bit m_cmd;

  always #5 clk = ~clk;

  home_menu_ctrl #(.NUM_DEV(NUM_DEV), .DEV_W(DEV_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_class(dec_class),
    .menu_level(menu_level), .cur_dev(cur_dev), .cur_opt(cur_opt),
    .cmd_valid(cmd_valid), .cmd_dev(cmd_dev), .cmd_on(cmd_on)
  );

  task automatic chk(string req, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // returns the requirement tag that the decision exercises, updates model
  function automatic string model_step(bit v, logic [1:0] c);
    string tag;
    m_cmd = 0;
    if (!v || c == 2'b00 || c == 2'b11) return "R2";
    if (m_lvl == 0) begin
      if (c == 2'b01) begin
        tag = (m_dev == NUM_DEV - 1) ? "R4" : "R3";
        m_dev = (m_dev + 1) % NUM_DEV;
      end else begin
        tag = "R5"; m_lvl = 1; m_opt = 0;
      end
    end else begin
      if (c == 2'b01) begin
        tag = "R6"; m_opt = (m_opt + 1) % 3;
      end else if (m_opt == 2) begin
        tag = "R8"; m_lvl = 0; m_opt = 0;
      end else begin
        tag = "R7"; m_cmd = 1; m_cmd_dev = m_dev; m_cmd_on = (m_opt == 0);
        m_lvl = 0; m_opt = 0;
      end
    end
    return tag;
  endfunction

  task automatic compare(string tag);
    chk(tag, "menu_level", int'(menu_level), m_lvl);
    chk(tag, "cur_dev", int'(cur_dev), m_dev);
    chk(tag, "cur_opt", int'(cur_opt), m_opt);
    chk(m_cmd ? tag : "R9", "cmd_valid", int'(cmd_valid), int'(m_cmd));
    if (m_cmd) begin
      chk("R7", "cmd_dev", int'(cmd_dev), m_cmd_dev);
      chk("R7", "cmd_on", int'(cmd_on), m_cmd_on);
    end
  endtask

  // drive at a falling edge, check at the next falling edge
  task automatic decide(bit v, logic [1:0] c);
    string tag;
    dec_valid = v;
    dec_class = c;
    tag = model_step(v, c);
    @(negedge clk);
    dec_valid = 1'b0;
    dec_class = 2'b00;
    compare(tag);
  endtask

  initial begin
    m_lvl = 0; m_dev = 0; m_opt = 0; m_cmd = 0; m_cmd_dev = 0; m_cmd_on = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "menu_level", int'(menu_level), 0);
    chk("R1", "cur_dev", int'(cur_dev), 0);
    chk("R1", "cur_opt", int'(cur_opt), 0);
    chk("R1", "cmd_valid", int'(cmd_valid), 0);

    // R3 and R4: full lap of the device list
    for (int i = 0; i < NUM_DEV + 1; i++) decide(1'b1, 2'b01);
    // R2: malformed and absent strobes
    decide(1'b1, 2'b11);
    decide(1'b1, 2'b00);
    decide(1'b0, 2'b10);
    // R5, R6, R8: enter, cycle to return, confirm return
    decide(1'b1, 2'b10);
    decide(1'b1, 2'b01);
    decide(1'b1, 2'b01);
    decide(1'b1, 2'b10);
    // R7: switch-on for current device
    decide(1'b1, 2'b10);
    decide(1'b1, 2'b10);
    // R9: command cannot repeat next cycle, idle
    decide(1'b0, 2'b00);
    // R7: switch-off on the last device
    decide(1'b1, 2'b01);
    decide(1'b1, 2'b01);
    decide(1'b1, 2'b10);
    decide(1'b1, 2'b01);
    decide(1'b1, 2'b11);
    decide(1'b1, 2'b10);
    // R6: full option lap
    decide(1'b1, 2'b10);
    for (int i = 0; i < 3; i++) decide(1'b1, 2'b01);
    decide(1'b1, 2'b10);

    // random decisions with a fixed seed
    void'($urandom(32'd1357));
    for (int i = 0; i < 3000; i++) begin
      bit v;
      logic [1:0] c;
      v = ($urandom % 8) != 0;
      c = 2'($urandom);
      decide(v, c);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule